// File: doc/BRIEF.md
# I2C Client Interrupt Flag Register

This block keeps the six sticky event flags of an I2C client (target) peripheral and raises the interrupt request line from them. The surrounding client logic reports each event as a one-cycle pulse or as a FIFO level. The block sets the matching flag and holds it. Software clears a flag by writing a one to its bit. Several flags are also cleared by hardware when particular register accesses or bus conditions occur.

When software clears the address-match flag, the bus logic must answer the address with an ACK or a NACK. For this the block produces a one-cycle launch pulse, together with the acknowledge choice that was captured when the clear was written. The bus state machine, the address comparator, the FIFOs and the error detectors all live outside this block and reach it only as inputs.

Top module: `i2cIrqFlags`

## Requirements
- R1: After reset `flags` is 0x00, and `irq` and `ackLaunch` are 0.
- R2: A write with `regWrEn` clears every flag whose data bit is 1 and leaves every flag whose data bit is 0 unchanged. Bits 6 and 5 always read 0 and ignore writes. The flag positions are: bit 7 error, bit 4 receive-threshold, bit 3 transmit-threshold, bit 2 data-ready, bit 1 address-match, bit 0 stop.
- R3: A pulse on any of `errLength`, `errClkExt`, `errLowTime`, `errCollide` or `errBus` sets bit 7 on the next clock.
- R4: Bit 4 is set on the clock after `rxCount` first reaches `rxThresh` (when `rxThresh` is nonzero). It is not set again while the count stays at or above the threshold. It is cleared when `rxCount` is 0.
- R5: Bit 3 is set on the clock after `txFree` first reaches `txThresh` (when `txThresh` is nonzero). It is not set again while the free count stays at or above the threshold. It is cleared when `txFree` is 0.
- R6: `byteDone` sets bit 2. Any of the following clears it: `dataWr`; `dataRd` while `smartEn` is 1; `cmdWr` while `cmdValid` is 1. A read with `smartEn` at 0, or `cmdWr` with `cmdValid` at 0, leaves it unchanged.
- R7: `addrMatch` sets bit 1. Any `cmdWr` clears it.
- R8: A software write that actually clears bit 1 makes `ackLaunch` high for exactly the next cycle. In that same cycle `ackNack` holds the value `ackAct` had at the write.
- R9: `stopSeen` sets bit 0 only if `stopOwn` or `groupCmdEn` is 1.
- R10: While bit 0 is set, a `cmdWr` clears it only if an `addrMatch` pulse has occurred since bit 0 was set.
- R11: When a set event and any clear of the same flag fall in one cycle, the flag ends up set. A software clear of bit 1 that loses in this way launches no ACK/NACK.
- R12: `irq` is 1 exactly when some bit of `flags & irqEn` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Software write strobe for the flag register |
| regWrData | input | 8 | Write data; each 1 clears its flag |
| dataWr | input | 1 | Data register written |
| dataRd | input | 1 | Data register read |
| smartEn | input | 1 | Smart mode enabled |
| cmdWr | input | 1 | Command field written |
| cmdValid | input | 1 | Written command is valid |
| byteDone | input | 1 | Client byte transfer completed |
| addrMatch | input | 1 | Valid matching address received |
| stopSeen | input | 1 | Stop condition detected on the bus |
| stopOwn | input | 1 | Stop belongs to a transaction of this client |
| groupCmdEn | input | 1 | Group-command mode enabled |
| errLength | input | 1 | Length error pulse |
| errClkExt | input | 1 | Extended clock timeout pulse |
| errLowTime | input | 1 | Clock-low timeout pulse |
| errCollide | input | 1 | Collision pulse |
| errBus | input | 1 | Bus error pulse |
| rxCount | input | LEVEL_W | Receive FIFO fill level |
| rxThresh | input | LEVEL_W | Receive FIFO threshold |
| txFree | input | LEVEL_W | Free locations in transmit FIFO |
| txThresh | input | LEVEL_W | Transmit FIFO threshold |
| ackAct | input | 1 | Acknowledge choice: 0 ACK, 1 NACK |
| irqEn | input | 8 | Per-bit interrupt enable |
| flags | output | 8 | Flag byte |
| irq | output | 1 | Combined interrupt request |
| ackLaunch | output | 1 | One-cycle ACK/NACK launch pulse |
| ackNack | output | 1 | Acknowledge choice for the launch |

## Verification
The write-one-to-clear path is swept over all 256 write values, each from a state with every flag set. This separates per-bit independence, reserved-bit masking and the launch of the acknowledge from one another. The interrupt line is swept over all 256 enable masks against a fixed flag pattern. Each hardware clear source is driven on its own and also in its disqualified form (smart mode off, invalid command, a command before any address match). This shows that every qualifier is actually tested. Same-cycle set and clear pairs and the FIFO levels held at threshold confirm that events are neither lost nor repeated.

// File: rtl/i2cIrqPkg.sv
package i2cIrqPkg;
  localparam int FLAG_W     = 8;
  localparam int BIT_ERR    = 7;
  localparam int BIT_RXF    = 4;
  localparam int BIT_TXE    = 3;
  localparam int BIT_DRDY   = 2;
  localparam int BIT_AMATCH = 1;
  localparam int BIT_STOP   = 0;
  localparam logic [FLAG_W-1:0] LIVE_MASK = 8'h9F;

  typedef struct packed {
    logic [FLAG_W-1:0] setMask;
    logic [FLAG_W-1:0] clrMask;
    logic              ackFire;
  } flagStrobe_t;
endpackage

// File: rtl/i2cIrqCtrl.sv
module i2cIrqCtrl
  import i2cIrqPkg::*;
#(
  parameter int LEVEL_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [FLAG_W-1:0]   regWrData,
  input  logic                dataWr,
  input  logic                dataRd,
  input  logic                smartEn,
  input  logic                cmdWr,
  input  logic                cmdValid,
  input  logic                byteDone,
  input  logic                addrMatch,
  input  logic                stopSeen,
  input  logic                stopOwn,
  input  logic                groupCmdEn,
  input  logic [4:0]          errPulses,
  input  logic [LEVEL_W-1:0]  rxCount,
  input  logic [LEVEL_W-1:0]  rxThresh,
  input  logic [LEVEL_W-1:0]  txFree,
  input  logic [LEVEL_W-1:0]  txThresh,
  input  logic [FLAG_W-1:0]   flagsNow,
  output flagStrobe_t         strobe
);
  localparam logic [LEVEL_W-1:0] LEVEL_ZERO = '0;

  logic rxHit, txHit, rxHitQ, txHitQ;
  logic precArm, precArmNext;
  logic [FLAG_W-1:0] swClr, hwClr, setMask, clrMask;

  // threshold crossings are seen as rising edges of the level compare
  assign rxHit = (rxThresh != LEVEL_ZERO) && (rxCount >= rxThresh);
  assign txHit = (txThresh != LEVEL_ZERO) && (txFree >= txThresh);

  assign swClr = regWrEn ? (regWrData & LIVE_MASK) : '0;

  always_comb begin
    setMask             = '0;
    setMask[BIT_ERR]    = |errPulses;
    setMask[BIT_RXF]    = rxHit & ~rxHitQ;
    setMask[BIT_TXE]    = txHit & ~txHitQ;
    setMask[BIT_DRDY]   = byteDone;
    setMask[BIT_AMATCH] = addrMatch;
    setMask[BIT_STOP]   = stopSeen & (stopOwn | groupCmdEn);

    hwClr               = '0;
    hwClr[BIT_RXF]      = (rxCount == LEVEL_ZERO);
    hwClr[BIT_TXE]      = (txFree == LEVEL_ZERO);
    hwClr[BIT_DRDY]     = dataWr | (dataRd & smartEn) | (cmdWr & cmdValid);
    hwClr[BIT_AMATCH]   = cmdWr;
    hwClr[BIT_STOP]     = cmdWr & precArm;

    clrMask = swClr | hwClr;
  end

  // stop flag is armed for hardware clear by an address match seen while it is set
  assign precArmNext = (precArm | addrMatch) & flagsNow[BIT_STOP] & ~clrMask[BIT_STOP];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxHitQ  <= 1'b0;
      txHitQ  <= 1'b0;
      precArm <= 1'b0;
    end else begin
      rxHitQ  <= rxHit;
      txHitQ  <= txHit;
      precArm <= precArmNext;
    end
  end

  assign strobe.setMask = setMask;
  assign strobe.clrMask = clrMask;
  assign strobe.ackFire = swClr[BIT_AMATCH] & flagsNow[BIT_AMATCH] & ~setMask[BIT_AMATCH];
endmodule

// File: rtl/i2cIrqData.sv
module i2cIrqData
  import i2cIrqPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  flagStrobe_t       strobe,
  input  logic              ackAct,
  input  logic [FLAG_W-1:0] irqEn,
  output logic [FLAG_W-1:0] flags,
  output logic              irq,
  output logic              ackLaunch,
  output logic              ackNack
);
  logic [FLAG_W-1:0] flagReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagReg   <= '0;
      ackLaunch <= 1'b0;
      ackNack   <= 1'b0;
    end else begin
      // set is applied after clear, so a same-cycle event survives
      flagReg   <= ((flagReg & ~strobe.clrMask) | strobe.setMask) & LIVE_MASK;
      ackLaunch <= strobe.ackFire;
      if (strobe.ackFire) ackNack <= ackAct;
    end
  end

  assign flags = flagReg;
  assign irq   = |(flagReg & irqEn);
endmodule

// File: rtl/i2cIrqFlags.sv
module i2cIrqFlags
  import i2cIrqPkg::*;
#(
  parameter int LEVEL_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [7:0]         regWrData,
  input  logic               dataWr,
  input  logic               dataRd,
  input  logic               smartEn,
  input  logic               cmdWr,
  input  logic               cmdValid,
  input  logic               byteDone,
  input  logic               addrMatch,
  input  logic               stopSeen,
  input  logic               stopOwn,
  input  logic               groupCmdEn,
  input  logic               errLength,
  input  logic               errClkExt,
  input  logic               errLowTime,
  input  logic               errCollide,
  input  logic               errBus,
  input  logic [LEVEL_W-1:0] rxCount,
  input  logic [LEVEL_W-1:0] rxThresh,
  input  logic [LEVEL_W-1:0] txFree,
  input  logic [LEVEL_W-1:0] txThresh,
  input  logic               ackAct,
  input  logic [7:0]         irqEn,
  output logic [7:0]         flags,
  output logic               irq,
  output logic               ackLaunch,
  output logic               ackNack
);
  flagStrobe_t strobe;
  logic [4:0]  errPulses;

  assign errPulses = {errLength, errClkExt, errLowTime, errCollide, errBus};

  i2cIrqCtrl #(.LEVEL_W(LEVEL_W)) ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .dataWr(dataWr), .dataRd(dataRd), .smartEn(smartEn),
    .cmdWr(cmdWr), .cmdValid(cmdValid), .byteDone(byteDone),
    .addrMatch(addrMatch), .stopSeen(stopSeen), .stopOwn(stopOwn),
    .groupCmdEn(groupCmdEn), .errPulses(errPulses),
    .rxCount(rxCount), .rxThresh(rxThresh), .txFree(txFree), .txThresh(txThresh),
    .flagsNow(flags), .strobe(strobe)
  );

  i2cIrqData data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ackAct(ackAct), .irqEn(irqEn),
    .flags(flags), .irq(irq), .ackLaunch(ackLaunch), .ackNack(ackNack)
  );
endmodule

// File: rtl/i2cIrqChk.sv
module i2cIrqChk #(
  parameter int LEVEL_W = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               regWrEn,
  input logic [7:0]         regWrData,
  input logic               byteDone,
  input logic               addrMatch,
  input logic [4:0]         errAny,
  input logic [LEVEL_W-1:0] rxCount,
  input logic [LEVEL_W-1:0] txFree,
  input logic [7:0]         irqEn,
  input logic [7:0]         flags,
  input logic               irq,
  input logic               ackLaunch
);
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    flags[6:5] == 2'b00);

  assert_err_sets_R3: assert property (@(posedge clk) disable iff (!rstN)
    (|errAny) |=> flags[7]);

  assert_rx_empty_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rxCount == '0) |=> !flags[4]);

  assert_tx_full_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    (txFree == '0) |=> !flags[3]);

  assert_drdy_set_R6: assert property (@(posedge clk) disable iff (!rstN)
    byteDone |=> flags[2]);

  assert_amatch_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    addrMatch |=> flags[1]);

  assert_ack_launch_R8: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regWrData[1] && flags[1] && !addrMatch) |=> ackLaunch);

  assert_ack_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    ackLaunch |-> ($past(regWrEn) && $past(flags[1]) && !flags[1]));

  assert_irq_masked_R12: assert property (@(posedge clk) disable iff (!rstN)
    (irqEn == 8'h00) |-> !irq);
endmodule

bind i2cIrqFlags i2cIrqChk #(.LEVEL_W(LEVEL_W)) chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
  .byteDone(byteDone), .addrMatch(addrMatch),
  .errAny({errLength, errClkExt, errLowTime, errCollide, errBus}),
  .rxCount(rxCount), .txFree(txFree), .irqEn(irqEn),
  .flags(flags), .irq(irq), .ackLaunch(ackLaunch)
);

// File: tb/tb_i2cIrqFlags.sv
module tb_i2cIrqFlags;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 4;
  localparam logic [LW-1:0] THR = 4'd4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 0, dataWr = 0, dataRd = 0, smartEn = 0, cmdWr = 0, cmdValid = 0;
  logic byteDone = 0, addrMatch = 0, stopSeen = 0, stopOwn = 0, groupCmdEn = 0;
  logic errLength = 0, errClkExt = 0, errLowTime = 0, errCollide = 0, errBus = 0;
  logic ackAct = 0;
  logic [7:0] regWrData = '0, irqEn = '0;
  logic [LW-1:0] rxCount = '0, rxThresh = THR, txFree = '0, txThresh = THR;
  logic [7:0] flags;
  logic irq, ackLaunch, ackNack;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2cIrqFlags #(.LEVEL_W(LW)) dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .dataWr(dataWr), .dataRd(dataRd), .smartEn(smartEn), .cmdWr(cmdWr), .cmdValid(cmdValid),
    .byteDone(byteDone), .addrMatch(addrMatch), .stopSeen(stopSeen), .stopOwn(stopOwn),
    .groupCmdEn(groupCmdEn), .errLength(errLength), .errClkExt(errClkExt),
    .errLowTime(errLowTime), .errCollide(errCollide), .errBus(errBus),
    .rxCount(rxCount), .rxThresh(rxThresh), .txFree(txFree), .txThresh(txThresh),
    .ackAct(ackAct), .irqEn(irqEn), .flags(flags), .irq(irq),
    .ackLaunch(ackLaunch), .ackNack(ackNack)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // inputs change after a falling edge; one tick passes a rising edge and stops at the next falling edge
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic dropPulses();
    regWrEn = 0; dataWr = 0; dataRd = 0; cmdWr = 0; byteDone = 0; addrMatch = 0;
    stopSeen = 0; errLength = 0; errClkExt = 0; errLowTime = 0; errCollide = 0; errBus = 0;
  endtask

  task automatic pulse();
    tick();
    dropPulses();
  endtask

  task automatic swWrite(input logic [7:0] v);
    regWrEn = 1; regWrData = v;
    pulse();
  endtask

  task automatic setAll();
    rxCount = '0; txFree = '0;
    tick();
    rxCount = THR; txFree = THR;
    errBus = 1; byteDone = 1; addrMatch = 1; stopSeen = 1; stopOwn = 1;
    pulse();
    stopOwn = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); tick();
    // R1: values held in reset
    check("R1 flags", {24'd0, flags}, 32'h00);
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 ackLaunch", {31'd0, ackLaunch}, 32'd0);
    rstN = 1;
    rxCount = '0; txFree = '0;
    tick();

    // R2 R8: sweep all write values from the all-set state
    for (int v = 0; v < 256; v++) begin
      setAll();
      check("R2 setAll", {24'd0, flags}, 32'h9F);
      ackAct = v[0];
      swWrite(v[7:0]);
      check("R2 w1c sweep", {24'd0, flags}, {24'd0, 8'h9F & ~v[7:0]});
      check("R8 launch", {31'd0, ackLaunch}, {31'd0, v[1]});
      if (v[1]) check("R8 nack choice", {31'd0, ackNack}, {31'd0, v[0]});
      tick();
      check("R8 one cycle", {31'd0, ackLaunch}, 32'd0);
    end
    swWrite(8'hFF);
    check("R2 clear all", {24'd0, flags}, 32'h00);

    // R12: interrupt enable sweep against flags 0x85 (error, data-ready, stop)
    errBus = 1; byteDone = 1; stopSeen = 1; stopOwn = 1; pulse(); stopOwn = 0;
    check("R12 pattern", {24'd0, flags}, 32'h85);
    for (int m = 0; m < 256; m++) begin
      irqEn = m[7:0];
      #1;
      check("R12 irq", {31'd0, irq}, {31'd0, |(8'h85 & m[7:0])});
    end
    irqEn = '0;
    swWrite(8'hFF);

    // R3: every error source alone
    for (int e = 0; e < 5; e++) begin
      {errLength, errClkExt, errLowTime, errCollide, errBus} = 5'b1 << e;
      pulse();
      check("R3 error source", {31'd0, flags[7]}, 32'd1);
      swWrite(8'h80);
      check("R3 cleared", {31'd0, flags[7]}, 32'd0);
    end

    // R4: receive threshold crossing
    rxCount = 4'd3; tick();
    check("R4 below thresh", {31'd0, flags[4]}, 32'd0);
    rxCount = THR; tick();
    check("R4 reach thresh", {31'd0, flags[4]}, 32'd1);
    swWrite(8'h10);
    rxCount = 4'd6; tick(); tick();
    check("R4 no re-set while above", {31'd0, flags[4]}, 32'd0);
    rxCount = 4'd2; tick(); rxCount = THR; tick();
    check("R4 re-cross", {31'd0, flags[4]}, 32'd1);
    rxCount = 4'd0; tick();
    check("R4 empty clears", {31'd0, flags[4]}, 32'd0);

    // R5: transmit free-space crossing
    txFree = 4'd3; tick();
    check("R5 below thresh", {31'd0, flags[3]}, 32'd0);
    txFree = 4'd5; tick();
    check("R5 reach thresh", {31'd0, flags[3]}, 32'd1);
    txFree = 4'd1; tick();
    check("R5 partial keeps", {31'd0, flags[3]}, 32'd1);
    txFree = 4'd0; tick();
    check("R5 full clears", {31'd0, flags[3]}, 32'd0);

    // R6: data-ready clears and their disqualified forms
    byteDone = 1; pulse();
    dataRd = 1; smartEn = 0; pulse();
    check("R6 read no smart", {31'd0, flags[2]}, 32'd1);
    cmdWr = 1; cmdValid = 0; pulse();
    check("R6 invalid cmd", {31'd0, flags[2]}, 32'd1);
    dataRd = 1; smartEn = 1; pulse(); smartEn = 0;
    check("R6 smart read", {31'd0, flags[2]}, 32'd0);
    byteDone = 1; pulse(); dataWr = 1; pulse();
    check("R6 data write", {31'd0, flags[2]}, 32'd0);
    byteDone = 1; pulse(); cmdWr = 1; cmdValid = 1; pulse(); cmdValid = 0;
    check("R6 valid cmd", {31'd0, flags[2]}, 32'd0);

    // R7: address match set and command clear
    addrMatch = 1; pulse();
    check("R7 set", {31'd0, flags[1]}, 32'd1);
    cmdWr = 1; pulse();
    check("R7 cmd clears", {31'd0, flags[1]}, 32'd0);
    check("R8 no launch on hw clear", {31'd0, ackLaunch}, 32'd0);

    // R9: stop qualification
    for (int q = 0; q < 4; q++) begin
      stopSeen = 1; stopOwn = q[0]; groupCmdEn = q[1];
      pulse();
      check("R9 stop qualify", {31'd0, flags[0]}, {31'd0, q[0] | q[1]});
      swWrite(8'h01);
    end
    stopOwn = 0; groupCmdEn = 0;

    // R10: stop cleared by a command only after a new address match
    stopSeen = 1; stopOwn = 1; pulse(); stopOwn = 0;
    cmdWr = 1; pulse();
    check("R10 cmd without match", {31'd0, flags[0]}, 32'd1);
    addrMatch = 1; pulse();
    check("R10 armed keeps", {31'd0, flags[0]}, 32'd1);
    cmdWr = 1; pulse();
    check("R10 cmd after match", {31'd0, flags[0]}, 32'd0);

    // R11: set beats clear in the same cycle
    byteDone = 1; dataWr = 1; pulse();
    check("R11 drdy hw", {31'd0, flags[2]}, 32'd1);
    byteDone = 1; regWrEn = 1; regWrData = 8'h04; pulse();
    check("R11 drdy sw", {31'd0, flags[2]}, 32'd1);
    addrMatch = 1; pulse();
    addrMatch = 1; regWrEn = 1; regWrData = 8'h02; pulse();
    check("R11 amatch sw", {31'd0, flags[1]}, 32'd1);
    check("R11 no launch", {31'd0, ackLaunch}, 32'd0);
    errBus = 1; regWrEn = 1; regWrData = 8'h80; pulse();
    check("R11 error sw", {31'd0, flags[7]}, 32'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule